// File: doc/BRIEF.md
# PLL Configuration Register with Write Interlocks

This block is a single 32-bit memory-mapped register that holds the settings of a phase-locked loop. The settings are the reference source select, the input divider, the feedback multiplier, three output dividers (P, Q and R) and one enable for each of those three outputs. A simple bus slave port reaches the register. Writes complete in one cycle and carry byte-lane strobes. Reads are combinational and return data in the same cycle as the request.

Two live status inputs shape every write. `pll_running` reports that the loop is active. `r_is_sysclk` reports that the R output is currently the system clock. The block takes these two signals as a lock mode and keeps the relevant bits frozen. Any write that tries to change a frozen bit is dropped for those bits and raises a one-cycle `wr_ignored` pulse. There are four lock modes, named by `{pll_running, r_is_sysclk}`:

- LK_OPEN (00): all fields are writable.
- LK_SYSCLK_ONLY (01): only the R enable is frozen.
- LK_RUN (10): all divider, multiplier and source fields are frozen.
- LK_RUN_SYSCLK (11): those fields and the R enable are frozen.

These modes are decoded combinationally from the status pins on every cycle. There is no transition history: the mode moves straight to whatever the pins currently show.

The register also drives each field out as its own decoded output. These include:

- the effective R divide ratio, equal to the code plus one;
- an error flag for the reserved R code 000;
- a gated R enable that is true only while the loop runs.

Top module: `pll_cfg_reg`

## Requirements
- R1: After reset, a read at offset 0x0C returns 0x22040100. This value gives an R code of 001, a Q code of 001, a P code of 00010, a multiplier of 1, and zero for every other field.
- R2: A write updates only the byte lanes whose `bus_wstrb` bit is set. Strobe bit i covers data bits 8i+7 down to 8i.
- R3: Reserved bits 23, 22, 15, 7, 3 and 2 ignore writes and always read as zero.
- R4: Only address 0x0C selects the register. A write to any other address changes nothing, and a read from any other address returns zero.
- R5: While `pll_running` is high, writes leave these fields unchanged: the R code (bits 31:29), the Q code (27:25), the P code (21:17), the multiplier (14:8), the input divider (6:4) and the source select (1:0).
- R6: The P enable (bit 16), the Q enable (bit 24) and the R enable (bit 28) stay writable while the loop runs, subject to R7.
- R7: While `r_is_sysclk` is high, writes leave the R enable (bit 28) unchanged.
- R8: `r_ratio` equals the R code plus one. `r_code_err` is high exactly when the R code is 000.
- R9: `r_en_gated` is high exactly when the R enable is set and `pll_running` is high.
- R10: `wr_ignored` is high for the one cycle after a write to 0x0C that tried to change at least one writable bit frozen by R5 or R7. In every other case it is low.
- R11: The decoded field outputs always equal the corresponding bit ranges of the stored register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wstrb | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the request |
| pll_running | input | 1 | The loop is active |
| r_is_sysclk | input | 1 | The R output drives the system clock |
| src_sel | output | 2 | Reference source select |
| in_div_code | output | 3 | Input divider code |
| mult_code | output | 7 | Feedback multiplier code |
| p_div_code | output | 5 | P divider code |
| p_en | output | 1 | P output enable |
| q_div_code | output | 3 | Q divider code |
| q_en | output | 1 | Q output enable |
| r_div_code | output | 3 | R divider code |
| r_en | output | 1 | R output enable |
| r_ratio | output | 4 | Effective R divide ratio |
| r_code_err | output | 1 | The R code is the reserved value |
| r_en_gated | output | 1 | R enable qualified by `pll_running` |
| wr_ignored | output | 1 | Pulse: the last write hit a frozen bit |

## Verification
The bench builds the block with its default parameters: an 8-bit address and the register at offset 0x0C. With these defaults, every strobe pattern can be swept in every one of the four lock modes. For each pattern, the expected register value and the expected `wr_ignored` pulse are worked out from bit masks in the bench. The bench also steps through all eight R codes, all four combinations of enable and running, and reads and writes at nearby addresses.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
    localparam int unsigned REG_W = 32;
    localparam int unsigned NLANE = REG_W / 8;

    localparam logic [REG_W-1:0] RST_VALUE     = 32'h2204_0100;
    localparam logic [REG_W-1:0] WRITABLE_MASK = 32'hFF3F_7F73;
    localparam logic [REG_W-1:0] FIELD_MASK    = 32'hEE3E_7F73;
    localparam logic [REG_W-1:0] REN_MASK      = 32'h1000_0000;

    localparam int unsigned R_LSB   = 29;
    localparam int unsigned REN_BIT = 28;
    localparam int unsigned Q_LSB   = 25;
    localparam int unsigned QEN_BIT = 24;
    localparam int unsigned P_LSB   = 17;
    localparam int unsigned PEN_BIT = 16;
    localparam int unsigned N_LSB   = 8;
    localparam int unsigned M_LSB   = 4;
    localparam int unsigned SRC_LSB = 0;

    typedef enum logic [1:0] {
        LK_OPEN        = 2'b00,
        LK_SYSCLK_ONLY = 2'b01,
        LK_RUN         = 2'b10,
        LK_RUN_SYSCLK  = 2'b11
    } lock_mode_t;
endpackage

// File: rtl/pll_cfg_lock.sv
module pll_cfg_lock
    import pll_cfg_pkg::*;
(
    input  logic             pll_running,
    input  logic             r_is_sysclk,
    output lock_mode_t       mode,
    output logic [REG_W-1:0] allow_mask
);
    always_comb begin
        mode = lock_mode_t'({pll_running, r_is_sysclk});
    end

    always_comb begin
        unique case (mode)
            LK_OPEN:        allow_mask = WRITABLE_MASK;
            LK_SYSCLK_ONLY: allow_mask = WRITABLE_MASK & ~REN_MASK;
            LK_RUN:         allow_mask = WRITABLE_MASK & ~FIELD_MASK;
            LK_RUN_SYSCLK:  allow_mask = WRITABLE_MASK & ~FIELD_MASK & ~REN_MASK;
            default:        allow_mask = '0;
        endcase
    end
endmodule

// File: rtl/pll_cfg_wmask.sv
module pll_cfg_wmask
    import pll_cfg_pkg::*;
(
    input  logic             wr_hit,
    input  logic [NLANE-1:0] wstrb,
    input  logic [REG_W-1:0] wdata,
    input  logic [REG_W-1:0] cur,
    input  logic [REG_W-1:0] allow_mask,
    output logic [REG_W-1:0] upd_mask,
    output logic             blocked
);
    logic [REG_W-1:0] lane_mask;
    logic [REG_W-1:0] frozen_diff;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        assign lane_mask[8*g +: 8] = {8{wstrb[g]}};
    end

    always_comb begin
        frozen_diff = (cur ^ wdata) & lane_mask & WRITABLE_MASK & ~allow_mask;
        upd_mask    = wr_hit ? (lane_mask & allow_mask) : '0;
        blocked     = wr_hit && (frozen_diff != '0);
    end
endmodule

// File: rtl/pll_cfg_decode.sv
module pll_cfg_decode
    import pll_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] cfg,
    input  logic             pll_running,
    output logic [1:0]       src_sel,
    output logic [2:0]       in_div_code,
    output logic [6:0]       mult_code,
    output logic [4:0]       p_div_code,
    output logic             p_en,
    output logic [2:0]       q_div_code,
    output logic             q_en,
    output logic [2:0]       r_div_code,
    output logic             r_en,
    output logic [3:0]       r_ratio,
    output logic             r_code_err,
    output logic             r_en_gated
);
    always_comb begin
        src_sel     = cfg[SRC_LSB +: 2];
        in_div_code = cfg[M_LSB +: 3];
        mult_code   = cfg[N_LSB +: 7];
        p_div_code  = cfg[P_LSB +: 5];
        p_en        = cfg[PEN_BIT];
        q_div_code  = cfg[Q_LSB +: 3];
        q_en        = cfg[QEN_BIT];
        r_div_code  = cfg[R_LSB +: 3];
        r_en        = cfg[REN_BIT];
        r_ratio     = {1'b0, r_div_code} + 4'd1;
        r_code_err  = (r_div_code == 3'b000);
        r_en_gated  = r_en && pll_running;
    end

    // R8: the reserved code always maps to ratio 1, valid codes to 2..8
    a_r8_err_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        r_code_err |-> (r_ratio == 4'd1));
    a_r8_ratio_range: assert property (@(posedge clk) disable iff (!rst_n)
        !r_code_err |-> (r_ratio >= 4'd2 && r_ratio <= 4'd8));
    // R9: the gated enable never appears while the loop is stopped
    a_r9_gate: assert property (@(posedge clk) disable iff (!rst_n)
        r_en_gated |-> (pll_running && r_en));
endmodule

// File: rtl/pll_cfg_reg.sv
module pll_cfg_reg
    import pll_cfg_pkg::*;
#(
    parameter int unsigned           ADDR_W     = 8,
    parameter logic [ADDR_W-1:0]     REG_OFFSET = 8'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_wstrb,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              pll_running,
    input  logic              r_is_sysclk,
    output logic [1:0]        src_sel,
    output logic [2:0]        in_div_code,
    output logic [6:0]        mult_code,
    output logic [4:0]        p_div_code,
    output logic              p_en,
    output logic [2:0]        q_div_code,
    output logic              q_en,
    output logic [2:0]        r_div_code,
    output logic              r_en,
    output logic [3:0]        r_ratio,
    output logic              r_code_err,
    output logic              r_en_gated,
    output logic              wr_ignored
);
    logic [REG_W-1:0] cfg_q;
    logic [REG_W-1:0] allow_mask;
    logic [REG_W-1:0] upd_mask;
    logic             blocked;
    logic             addr_hit;
    logic             wr_hit;
    lock_mode_t       mode;

    assign addr_hit = bus_sel && (bus_addr == REG_OFFSET);
    assign wr_hit   = addr_hit && bus_wr;

    pll_cfg_lock u_lock (
        .pll_running (pll_running),
        .r_is_sysclk (r_is_sysclk),
        .mode        (mode),
        .allow_mask  (allow_mask)
    );

    pll_cfg_wmask u_wmask (
        .wr_hit     (wr_hit),
        .wstrb      (bus_wstrb),
        .wdata      (bus_wdata),
        .cur        (cfg_q),
        .allow_mask (allow_mask),
        .upd_mask   (upd_mask),
        .blocked    (blocked)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= RST_VALUE;
            wr_ignored <= 1'b0;
        end else begin
            cfg_q      <= (cfg_q & ~upd_mask) | (bus_wdata & upd_mask);
            wr_ignored <= blocked;
        end
    end

    always_comb begin
        bus_rdata = (addr_hit && !bus_wr) ? cfg_q : '0;
    end

    pll_cfg_decode u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg         (cfg_q),
        .pll_running (pll_running),
        .src_sel     (src_sel),
        .in_div_code (in_div_code),
        .mult_code   (mult_code),
        .p_div_code  (p_div_code),
        .p_en        (p_en),
        .q_div_code  (q_div_code),
        .q_en        (q_en),
        .r_div_code  (r_div_code),
        .r_en        (r_en),
        .r_ratio     (r_ratio),
        .r_code_err  (r_code_err),
        .r_en_gated  (r_en_gated)
    );

    // R2: an unstrobed lane keeps its contents across a write
    for (genvar g = 0; g < NLANE; g++) begin : g_lane_chk
        a_r2_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_sel && bus_wr && !bus_wstrb[g]) |=> $stable(cfg_q[8*g +: 8]));
    end

    // R3: reserved positions read back as zero
    a_r3_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |-> ((bus_rdata & ~WRITABLE_MASK) == '0));
    // R4: writes elsewhere leave the register alone
    a_r4_miss_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr != REG_OFFSET) |=> $stable(cfg_q));
    // R5: frozen fields hold while the loop runs
    a_r5_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pll_running |=> $stable(cfg_q & FIELD_MASK));
    // R7: R enable holds while R output is the system clock
    a_r7_ren_hold: assert property (@(posedge clk) disable iff (!rst_n)
        r_is_sysclk |=> $stable(cfg_q[REN_BIT]));
    // R10: the pulse always follows a write request
    a_r10_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ignored |-> $past(bus_sel && bus_wr));
    // R10: an open lock mode never produces a pulse
    a_r10_open_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LK_OPEN) |=> !wr_ignored);
endmodule

// File: tb/sim_pll_cfg_reg.sv
module sim_pll_cfg_reg;
    localparam logic [31:0] WR_M  = 32'hFF3F_7F73;
    localparam logic [31:0] FLD_M = 32'hEE3E_7F73;
    localparam logic [31:0] REN_M = 32'h1000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [3:0]  bus_wstrb = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pll_running = 1'b0;
    logic        r_is_sysclk = 1'b0;
    logic [1:0]  src_sel;
    logic [2:0]  in_div_code;
    logic [6:0]  mult_code;
    logic [4:0]  p_div_code;
    logic        p_en;
    logic [2:0]  q_div_code;
    logic        q_en;
    logic [2:0]  r_div_code;
    logic        r_en;
    logic [3:0]  r_ratio;
    logic        r_code_err;
    logic        r_en_gated;
    logic        wr_ignored;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    logic [31:0] exp_reg;

    always #5 clk = ~clk;

    pll_cfg_reg u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wstrb(bus_wstrb), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pll_running(pll_running), .r_is_sysclk(r_is_sysclk),
        .src_sel(src_sel), .in_div_code(in_div_code), .mult_code(mult_code),
        .p_div_code(p_div_code), .p_en(p_en), .q_div_code(q_div_code), .q_en(q_en),
        .r_div_code(r_div_code), .r_en(r_en), .r_ratio(r_ratio),
        .r_code_err(r_code_err), .r_en_gated(r_en_gated), .wr_ignored(wr_ignored)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [3:0] s, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wstrb = s; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_wstrb = '0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    function automatic logic [31:0] lanes(input logic [3:0] s);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{s[i]}};
        return m;
    endfunction

    function automatic logic [31:0] allowed(input bit run, input bit sys);
        logic [31:0] m;
        m = WR_M;
        if (run) m = m & ~FLD_M;
        if (sys) m = m & ~REN_M;
        return m;
    endfunction

    task automatic model_write(input logic [3:0] s, input logic [31:0] d, output bit ign);
        logic [31:0] al;
        logic [31:0] lm;
        al = allowed(pll_running, r_is_sysclk);
        lm = lanes(s);
        ign = (((exp_reg ^ d) & lm & WR_M & ~al) != 0);
        exp_reg = (exp_reg & ~(lm & al)) | (d & lm & al);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        bit ign;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_reg = 32'h2204_0100;

        // R1: reset value and decoded fields
        do_read(8'h0C, rd);
        check("R1 reset value", rd, exp_reg);
        check("R1 reset ratio", {28'd0, r_ratio}, 32'd2);
        check("R1 reset err", {31'd0, r_code_err}, 32'd0);
        check("R10 no pulse after reset", {31'd0, wr_ignored}, 32'd0);

        // R4: other addresses
        do_read(8'h08, rd);
        check("R4 read miss", rd, 32'd0);
        do_write(8'h10, 4'hF, 32'hFFFF_FFFF);
        do_read(8'h0C, rd);
        check("R4 write miss", rd, exp_reg);
        check("R4 no pulse on miss", {31'd0, wr_ignored}, 32'd0);

        // R2, R3, R11: strobe sweep with loop stopped
        for (int s = 0; s < 16; s++) begin
            logic [31:0] d;
            d = 32'hA5C3_96F0 ^ (32'(s) * 32'h1357_9BDF);
            model_write(4'(s), d, ign);
            do_write(8'h0C, 4'(s), d);
            check("R10 open write pulse", {31'd0, wr_ignored}, {31'd0, ign});
            do_read(8'h0C, rd);
            check("R2 lane merge", rd, exp_reg);
            check("R3 reserved zero", rd & ~WR_M, 32'd0);
            check("R11 mult field", {25'd0, mult_code}, {25'd0, exp_reg[14:8]});
            check("R11 p field", {27'd0, p_div_code}, {27'd0, exp_reg[21:17]});
            check("R11 src/m fields", {27'd0, src_sel, in_div_code},
                  {27'd0, exp_reg[1:0], exp_reg[6:4]});
        end

        // R5, R6, R7, R10: sweep every lock mode and strobe
        for (int m = 1; m < 4; m++) begin
            for (int s = 0; s < 16; s++) begin
                logic [31:0] d;
                @(negedge clk);
                pll_running = m[1];
                r_is_sysclk = m[0];
                d = ~exp_reg ^ (32'(s) << 3);
                model_write(4'(s), d, ign);
                do_write(8'h0C, 4'(s), d);
                check("R10 locked write pulse", {31'd0, wr_ignored}, {31'd0, ign});
                do_read(8'h0C, rd);
                check(m[1] ? "R5 R6 running write" : "R7 sysclk write", rd, exp_reg);
                check("R7 ren output", {31'd0, r_en}, {31'd0, exp_reg[28]});
            end
        end
        @(negedge clk);
        pll_running = 1'b0;
        r_is_sysclk = 1'b0;
        @(negedge clk);
        check("R10 pulse ends", {31'd0, wr_ignored}, 32'd0);

        // R8: every R code
        for (int c = 0; c < 8; c++) begin
            model_write(4'b1000, {3'(c), 29'd0}, ign);
            do_write(8'h0C, 4'b1000, {3'(c), 29'd0});
            check("R8 ratio", {28'd0, r_ratio}, 32'(c) + 32'd1);
            check("R8 err flag", {31'd0, r_code_err}, {31'd0, c == 0});
        end

        // R9: gated enable over enable x running
        for (int e = 0; e < 2; e++) begin
            for (int r = 0; r < 2; r++) begin
                @(negedge clk);
                pll_running = 1'b0;
                model_write(4'b1000, {3'b001, 1'(e), 28'd0}, ign);
                do_write(8'h0C, 4'b1000, {3'b001, 1'(e), 28'd0});
                pll_running = 1'(r);
                #1;
                check("R9 gated enable", {31'd0, r_en_gated}, {31'd0, (e == 1) && (r == 1)});
            end
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule